// File: doc/BRIEF.md
# Lockable PLD Configuration Store

This block holds the configuration of a small sum-of-products logic device: a grid of AND-array connection bits (one row per product term), a set of architecture bits (a global mode field plus a per-macrocell polarity and register/combinatorial select), a 64-bit signature word, and a sticky security bit. The connection rows and the architecture bits are driven in parallel onto output buses that feed the logic array and the macrocells. The signature is visible only through reads.

A single command port with a valid/ready handshake accepts seven operations. These are bulk erase, program a row, program the signature, program the architecture bits, set security, read a row, and read the signature. Programming a row can only make connections; opening a connection needs a bulk erase. Once security is set, every read and program command is refused with a one-cycle error pulse until a bulk erase has run. The erase wipes connections, architecture bits, signature and security together, and it keeps the port busy for a fixed number of cycles. Reset puts the store in the erased state.

Top module: `cfg_vault`

## Requirements
- R1: After reset, `busy` and `secured` are 0, `cmd_ready` is 1, and every bit of `array_bits`, `arch_mode`, `arch_pol` and `arch_reg` is 0 (all connections open).
- R2: An accepted program-row command (opcode 1) ORs `cmd_data[ROW_W-1:0]` into row `cmd_addr`. The row appears at `array_bits[cmd_addr*ROW_W +: ROW_W]` from the cycle after acceptance.
- R3: Programming never opens a connection. A 0 in the data of a program-row command leaves an existing 1 in that row unchanged.
- R4: An accepted architecture command (opcode 3) loads `arch_mode` from `cmd_data[1:0]`, `arch_pol` from `cmd_data[2 +: NCELL]` and `arch_reg` from `cmd_data[2+NCELL +: NCELL]`.
- R5: A program-signature command (opcode 2) stores `cmd_data`. Read-signature (opcode 6) and read-row (opcode 5, zero-extended) pulse `rd_valid` for one cycle, one cycle after acceptance, with the value on `rd_data`.
- R6: The set-security command (opcode 4) sets `secured` from the next cycle. A program command (opcodes 1–3) with `cmd_lock` high applies its data and sets `secured` in the same step. Only an erase clears `secured`.
- R7: While `secured` is 1, opcodes 1, 2, 3, 5 and 6 are refused. `err` pulses one cycle after acceptance, `rd_valid` stays 0, and no stored bit changes.
- R8: An accepted erase (opcode 0) clears connections, architecture bits, signature and security. It then holds `busy` high and `cmd_ready` low for exactly ERASE_CYCLES cycles, and no command offered in that time is taken.
- R9: Opcode 7 is refused with an `err` pulse and changes nothing.
- R10: `err` and `rd_valid` are never high together, and each is high only in the cycle after an accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | $clog2(ROWS) | Row number |
| cmd_lock | input | 1 | Set security with this program command |
| cmd_data | input | SIG_W | Program data |
| busy | output | 1 | Erase in progress |
| secured | output | 1 | Security bit |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | SIG_W | Read data |
| err | output | 1 | Refused-command pulse |
| array_bits | output | ROWS*ROW_W | All connection rows, row r at bits r*ROW_W upward |
| arch_mode | output | 2 | Global device mode bits |
| arch_pol | output | NCELL | Per-macrocell output polarity |
| arch_reg | output | NCELL | Per-macrocell registered select |

## Verification
The properties assume that `cmd_op`, `cmd_lock` and `cmd_addr` hold known values whenever `cmd_valid` is high. They also assume a row address below ROWS, which the default power-of-two depth guarantees. The bench drives every field at the falling edge and keeps each command for exactly one accepting edge. It never offers a command outside the encoded opcode set, except for the deliberate opcode 7. It also offers one command while an erase is running, to show that `cmd_ready` gates it.

// File: rtl/cfg_vault.sv
module cfg_vault #(
  parameter int ROWS = 64,
  parameter int ROW_W = 40,
  parameter int NCELL = 8,
  parameter int SIG_W = 64,
  parameter int ERASE_CYCLES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [2:0]            cmd_op,
  input  logic [$clog2(ROWS)-1:0] cmd_addr,
  input  logic                  cmd_lock,
  input  logic [SIG_W-1:0]      cmd_data,
  output logic                  busy,
  output logic                  secured,
  output logic                  rd_valid,
  output logic [SIG_W-1:0]      rd_data,
  output logic                  err,
  output logic [ROWS*ROW_W-1:0] array_bits,
  output logic [1:0]            arch_mode,
  output logic [NCELL-1:0]      arch_pol,
  output logic [NCELL-1:0]      arch_reg
);
  localparam int CW = $clog2(ERASE_CYCLES + 1);

  logic [ROW_W-1:0] mem [ROWS];
  logic [SIG_W-1:0] sig;
  logic [CW-1:0]    ecnt;
  logic             acc, guarded, refuse;

  assign busy      = (ecnt != '0);
  assign cmd_ready = !busy;
  assign acc       = cmd_valid && cmd_ready;
  assign guarded   = (cmd_op != 3'd0) && (cmd_op != 3'd4) && (cmd_op != 3'd7);
  assign refuse    = (cmd_op == 3'd7) || (secured && guarded);

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    assign array_bits[g*ROW_W +: ROW_W] = mem[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) mem[i] <= '0;
      sig       <= '0;
      secured   <= 1'b0;
      arch_mode <= '0;
      arch_pol  <= '0;
      arch_reg  <= '0;
      ecnt      <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      err       <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      err      <= 1'b0;
      if (busy) ecnt <= ecnt - 1'b1;
      if (acc) begin
        if (refuse) begin
          err <= 1'b1;
        end else begin
          case (cmd_op)
            3'd0: begin
              for (int i = 0; i < ROWS; i++) mem[i] <= '0;
              sig       <= '0;
              secured   <= 1'b0;
              arch_mode <= '0;
              arch_pol  <= '0;
              arch_reg  <= '0;
              ecnt      <= CW'(ERASE_CYCLES);
            end
            3'd1: begin
              mem[cmd_addr] <= mem[cmd_addr] | cmd_data[ROW_W-1:0];
              if (cmd_lock) secured <= 1'b1;
            end
            3'd2: begin
              sig <= cmd_data;
              if (cmd_lock) secured <= 1'b1;
            end
            3'd3: begin
              arch_mode <= cmd_data[1:0];
              arch_pol  <= cmd_data[2 +: NCELL];
              arch_reg  <= cmd_data[2+NCELL +: NCELL];
              if (cmd_lock) secured <= 1'b1;
            end
            3'd4: secured <= 1'b1;
            3'd5: begin
              rd_valid <= 1'b1;
              rd_data  <= SIG_W'(mem[cmd_addr]);
            end
            3'd6: begin
              rd_valid <= 1'b1;
              rd_data  <= sig;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cfg_vault_chk.sv
module cfg_vault_chk #(
  parameter int ROWS = 64,
  parameter int ROW_W = 40
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic [2:0]            cmd_op,
  input logic                  busy,
  input logic                  secured,
  input logic                  rd_valid,
  input logic                  err,
  input logic [ROWS*ROW_W-1:0] array_bits
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  assert_erase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 3'd0 |=> busy && !cmd_ready && !secured && array_bits == '0);

  assert_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && secured && (cmd_op inside {3'd1, 3'd2, 3'd3, 3'd5, 3'd6})
    |=> err && !rd_valid && secured && $stable(array_bits));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    secured && !(acc && cmd_op == 3'd0) |=> secured);

  assert_setsec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 3'd4 |=> secured);

  assert_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !secured && (cmd_op == 3'd5 || cmd_op == 3'd6) |=> rd_valid && !err);

  assert_badop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 3'd7 |=> err && $stable(array_bits));

  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && rd_valid));

  assert_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err || rd_valid) |-> $past(acc));
endmodule

bind cfg_vault cfg_vault_chk #(.ROWS(ROWS), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .busy(busy), .secured(secured), .rd_valid(rd_valid),
  .err(err), .array_bits(array_bits)
);

// File: tb/cfg_vault_tb.sv
module cfg_vault_tb;
  localparam int ROWS = 64, ROW_W = 40, NCELL = 8, SIG_W = 64, EC = 16;
  localparam int AW = $clog2(ROWS);

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_lock = 0;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [SIG_W-1:0] cmd_data = '0;
  logic cmd_ready, busy, secured, rd_valid, err;
  logic [SIG_W-1:0] rd_data;
  logic [ROWS*ROW_W-1:0] array_bits;
  logic [1:0] arch_mode;
  logic [NCELL-1:0] arch_pol, arch_reg;

  int checks = 0, failures = 0;
  bit q_kind[$];
  logic [SIG_W-1:0] q_data[$];
  string q_tag[$];

  always #4 clk = ~clk;

  cfg_vault #(.ROWS(ROWS), .ROW_W(ROW_W), .NCELL(NCELL), .SIG_W(SIG_W),
              .ERASE_CYCLES(EC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_lock(cmd_lock), .cmd_data(cmd_data),
    .busy(busy), .secured(secured), .rd_valid(rd_valid), .rd_data(rd_data),
    .err(err), .array_bits(array_bits), .arch_mode(arch_mode),
    .arch_pol(arch_pol), .arch_reg(arch_reg));

  task automatic chk(string tag, logic [SIG_W-1:0] act, logic [SIG_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [SIG_W-1:0] row(int r);
    return SIG_W'(array_bits[r*ROW_W +: ROW_W]);
  endfunction

  task automatic send(logic [2:0] op, int addr, logic [SIG_W-1:0] d, bit lock,
                      int kind, logic [SIG_W-1:0] exp, string tag);
    while (!cmd_ready) @(negedge clk);
    if (kind >= 0) begin
      q_kind.push_back(kind[0]);
      q_data.push_back(exp);
      q_tag.push_back(tag);
    end
    cmd_op = op; cmd_addr = AW'(addr); cmd_data = d; cmd_lock = lock; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0; cmd_lock = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && (rd_valid || err)) begin
      checks++;
      if (rd_valid && err) begin
        failures++;
        $display("FAIL R10 actual=rd_valid&err expected=one");
      end else if (q_kind.size() == 0) begin
        failures++;
        $display("FAIL R10 actual=unexpected pulse expected=none");
      end else begin
        automatic bit k = q_kind.pop_front();
        automatic logic [SIG_W-1:0] e = q_data.pop_front();
        automatic string t = q_tag.pop_front();
        if (k == 1'b0 && !(rd_valid && rd_data === e)) begin
          failures++;
          $display("FAIL %s actual=%b/%h expected=rd %h", t, rd_valid, rd_data, e);
        end else if (k == 1'b1 && !err) begin
          failures++;
          $display("FAIL %s actual=no err expected=err", t);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  localparam logic [SIG_W-1:0] A = 64'h00_00_00_A5_0F_33_C1;
  localparam logic [SIG_W-1:0] B = 64'h00_00_00_80_00_00_01;
  localparam logic [SIG_W-1:0] C = 64'h00_00_00_5A_00_0C_00;
  localparam logic [SIG_W-1:0] S = 64'hDEAD_BEEF_0123_4567;

  initial begin
    int n;
    logic [SIG_W-1:0] ad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", SIG_W'(busy), 0);
    chk("R1 ready", SIG_W'(cmd_ready), 1);
    chk("R1 secured", SIG_W'(secured), 0);
    chk("R1 array", SIG_W'(|array_bits), 0);
    chk("R1 arch", SIG_W'({arch_mode, arch_pol, arch_reg}), 0);

    send(3'd1, 3, A, 0, -1, 0, "");
    chk("R2 row3", row(3), A);
    send(3'd1, 63, B, 0, -1, 0, "");
    chk("R2 row63", row(63), B);
    chk("R2 row4 untouched", row(4), 0);
    send(3'd1, 3, C, 0, -1, 0, "");
    chk("R3 or-in", row(3), A | C);

    send(3'd5, 3, 0, 0, 0, A | C, "R5 read row");
    send(3'd2, 0, S, 0, -1, 0, "");
    send(3'd6, 0, 0, 0, 0, S, "R5 read sig");
    send(3'd6, 0, 0, 0, 0, S, "R5 read sig again");

    ad = SIG_W'({8'h3C, 8'hA5, 2'b10});
    send(3'd3, 0, ad, 0, -1, 0, "");
    chk("R4 mode", SIG_W'(arch_mode), 2'b10);
    chk("R4 pol", SIG_W'(arch_pol), 8'hA5);
    chk("R4 reg", SIG_W'(arch_reg), 8'h3C);

    send(3'd7, 0, '1, 0, 1, 0, "R9 bad op");
    chk("R9 row3 kept", row(3), A | C);

    send(3'd4, 0, 0, 0, -1, 0, "");
    chk("R6 set sec", SIG_W'(secured), 1);
    send(3'd1, 5, '1, 0, 1, 0, "R7 prog row refused");
    send(3'd6, 0, 0, 0, 1, 0, "R7 read sig refused");
    send(3'd5, 3, 0, 0, 1, 0, "R7 read row refused");
    send(3'd3, 0, '1, 0, 1, 0, "R7 arch refused");
    send(3'd2, 0, 0, 1, 1, 0, "R7 sig refused");
    @(negedge clk);
    chk("R7 row5 kept", row(5), 0);
    chk("R7 arch kept", SIG_W'({arch_mode, arch_pol, arch_reg}), SIG_W'({2'b10, 8'hA5, 8'h3C}));
    chk("R7 still secured", SIG_W'(secured), 1);

    send(3'd0, 0, 0, 0, -1, 0, "");
    n = 0;
    while (busy) begin
      n++;
      if (n == 1) begin
        chk("R8 ready low", SIG_W'(cmd_ready), 0);
        cmd_op = 3'd1; cmd_addr = AW'(1); cmd_data = '1; cmd_valid = 1;
      end
      if (n == 2) cmd_valid = 0;
      @(negedge clk);
    end
    cmd_valid = 0;
    chk("R8 busy cycles", SIG_W'(n), EC);
    chk("R8 unsecured", SIG_W'(secured), 0);
    chk("R8 array cleared", SIG_W'(|array_bits), 0);
    chk("R8 arch cleared", SIG_W'({arch_mode, arch_pol, arch_reg}), 0);
    send(3'd6, 0, 0, 0, 0, 0, "R8 sig cleared");

    send(3'd1, 7, B, 1, -1, 0, "");
    chk("R6 lock row applied", row(7), B);
    chk("R6 lock secured", SIG_W'(secured), 1);
    send(3'd5, 7, 0, 0, 1, 0, "R7 read after lock");
    send(3'd0, 0, 0, 0, -1, 0, "");
    while (busy) @(negedge clk);
    send(3'd5, 7, 0, 0, 0, 0, "R8 row7 erased");
    send(3'd5, 63, 0, 0, 0, 0, "R8 row63 erased");

    repeat (4) @(negedge clk);
    chk("R10 queue drained", SIG_W'(q_kind.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule